// File: doc/BRIEF.md
# Reset Controller with Sticky Cause Register

This block collects four reset sources and turns them into a system reset for peripherals and memory-mapped registers. The four sources are a power-on input, an external reset pin, a watchdog timeout pulse and a software request. It also produces a separate reset for the watchdog timer, which only power-on asserts. A RAM-valid flag reports whether memory contents survived the last reset.

A 4-bit cause record is kept across every reset except power-on. It is read as an 8-bit status register on a small synchronous register bus. Code can do three things with the bus:
- read which source caused the last reset;
- clear recorded causes through a separate write-only clear register;
- request a software reset by writing the status register.

A clear write that leaves the software bit in place while that bit is set also starts another software reset.

Top module: `reset_cause_ctrl`

## Requirements
- R1: The status register reads at offset 0x230 as {4'b0000, ext, sw, wdt, por}: bit 0 is power-on, bit 1 is watchdog, bit 2 is software and bit 3 is external pin. Bits 7:4 always read 0.
- R2: While por_n is low, sys_rst and wdt_rst are 1 and ram_valid is 0. After a power-on reset the status reads 0x01, whatever it held before.
- R3: Pin sources (por_n, ext_rst_n) pass through a two-flop synchroniser on release. sys_rst then stays 1 for HOLD_CYCLES (4) further cycles, so it is high for 6 sampled cycles after the pin rises. A one-cycle internal source (watchdog pulse or software request) holds sys_rst high for exactly 4 cycles.
- R4: While ext_rst_n is low, sys_rst is 1 and wdt_rst is 0. The event ORs bit 3 into the status and sets ram_valid to 1.
- R5: A one-cycle wdt_timeout pulse ORs bit 1 into the status and starts a system reset, with wdt_rst kept 0.
- R6: A write to offset 0x230 with data bit 2 set sets status bit 2 and starts a software reset, with wdt_rst 0. Other data bits written there have no effect, and a write with data bit 2 clear has no effect at all.
- R7: A write to offset 0x234 clears each status bit whose data bit is 1.
- R8: If status bit 2 is set, a write to 0x234 with data bit 2 clear starts a new software reset. A clear write with data bit 2 set, or any clear write while bit 2 is 0, starts none.
- R9: Reads of 0x234 and of any other offset return 0. Writes to any offset other than 0x230 and 0x234 have no effect.
- R10: Bus writes made while sys_rst is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_n | input | 1 | Asynchronous external reset pin, active low |
| wdt_timeout | input | 1 | One-cycle watchdog timeout pulse |
| addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational on addr |
| sys_rst | output | 1 | System reset for peripherals and registers, active high |
| wdt_rst | output | 1 | Watchdog timer reset, active high |
| ram_valid | output | 1 | RAM contents kept through the last reset |

## Verification
The bench builds the block with its default parameters: a 12-bit offset bus, the status and clear registers at 0x230 and 0x234, and a 4-cycle hold. The small hold keeps every reset episode short, so the bench can exact-count the high cycles of sys_rst for both pin and pulse sources. It can also chain several resets inside one run, which shows that causes accumulate across non-power-on resets and are wiped by a second power-on.

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl #(
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h230,
  parameter logic [ADDR_W-1:0] CLR_OFS = 'h234,
  parameter int HOLD_CYCLES = 4
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_rst_n,
  input  logic              wdt_timeout,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              sys_rst,
  output logic              wdt_rst,
  output logic              ram_valid
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] HOLD = CW'(HOLD_CYCLES);

  logic [1:0] por_q, ext_q;
  logic [CW-1:0] cnt;
  logic [3:0] status;
  logic por_phase;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) por_q <= 2'b00;
    else        por_q <= {por_q[0], 1'b1};

  always_ff @(posedge clk or negedge ext_rst_n)
    if (!ext_rst_n) ext_q <= 2'b00;
    else            ext_q <= {ext_q[0], 1'b1};

  wire por_act = ~por_q[1];
  wire ext_act = ~ext_q[1];
  wire wdt_evt = wdt_timeout & ~por_act;

  assign sys_rst = por_act | ext_act | (cnt != '0);

  wire bus_ok = wr_en & ~sys_rst;
  wire stat_wr = bus_ok & (addr == STAT_OFS);
  wire clr_wr = bus_ok & (addr == CLR_OFS);
  wire sw_req = (stat_wr & wdata[2]) | (clr_wr & status[2] & ~wdata[2]);
  wire src = por_act | ext_act | wdt_evt | sw_req;
  wire [3:0] clr_mask = clr_wr ? wdata[3:0] : 4'b0000;
  wire unused_hi = ^wdata[7:4];

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)         cnt <= HOLD;
    else if (src)       cnt <= HOLD;
    else if (cnt != '0) cnt <= cnt - 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)       status <= 4'b0001;
    else if (por_act) status <= 4'b0001;
    else              status <= (status & ~clr_mask) | {ext_act, sw_req, wdt_evt, 1'b0};

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)        por_phase <= 1'b1;
    else if (!sys_rst) por_phase <= 1'b0;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) ram_valid <= 1'b0;
    else if (!por_act && (ext_act || wdt_evt || sw_req)) ram_valid <= 1'b1;

  assign wdt_rst = por_phase & sys_rst;
  assign rdata = (addr == STAT_OFS) ? {4'b0000, status} : 8'h00;

  assert_hi_zero_R1: assert property (@(posedge clk) disable iff (!por_n)
    rdata[7:4] == 4'b0000);
  assert_other_reads_zero_R9: assert property (@(posedge clk) disable iff (!por_n)
    (addr != STAT_OFS) |-> rdata == 8'h00);
  assert_sw_write_R6: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && !sys_rst && addr == STAT_OFS && wdata[2]) |=> (status[2] && sys_rst));
  assert_wdt_only_por_R5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst) |-> !wdt_rst);
  assert_hold_after_pin_R3: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> (!$past(ext_act) && !$past(por_act)));
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!por_n)
    !(wr_en && !sys_rst && addr == CLR_OFS) |=> ((status & $past(status)) == $past(status)));
  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst && !ext_act && !wdt_timeout && !por_act && status[2] == 1'b0) |=> !status[2]);
endmodule

// File: tb/reset_cause_ctrl_test.sv
module reset_cause_ctrl_test;
  logic clk = 0, por_n = 0, ext_rst_n = 1, wdt_timeout = 0, wr_en = 0;
  logic [11:0] addr = 12'h000;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic sys_rst, wdt_rst, ram_valid;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  reset_cause_ctrl uut (.clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
    .wdt_timeout(wdt_timeout), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .sys_rst(sys_rst), .wdt_rst(wdt_rst), .ram_valid(ram_valid));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #1 wr_en = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic count_rst(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (!sys_rst) break;
      n++;
      if (n > 50) break;
    end
  endtask

  task automatic test_por;
    int n; logic [7:0] d;
    por_n = 0; #23;
    chk("R2 sys_rst in por", sys_rst, 1);
    chk("R2 wdt_rst in por", wdt_rst, 1);
    chk("R2 ram_valid in por", ram_valid, 0);
    @(negedge clk); por_n = 1;
    count_rst(n);
    chk("R3 por release hold", n, 6 - 1);
    chk("R2 wdt_rst after por", wdt_rst, 0);
    rd(12'h230, d); chk("R2 R1 status after por", d, 8'h01);
  endtask

  task automatic test_reads;
    logic [7:0] d;
    rd(12'h234, d); chk("R9 clear reg reads 0", d, 0);
    rd(12'h200, d); chk("R9 other offset reads 0", d, 0);
  endtask

  task automatic test_sw_write;
    int n; logic [7:0] d; bit saw_wdt;
    wr(12'h230, 8'hFB);
    @(negedge clk); chk("R6 no reset without bit2", sys_rst, 0);
    rd(12'h230, d); chk("R6 status unchanged", d, 8'h01);
    wr(12'h230, 8'hFF);
    saw_wdt = wdt_rst;
    count_rst(n);
    chk("R3 R6 sw reset length", n, 4);
    chk("R6 wdt_rst stays low", saw_wdt, 0);
    rd(12'h230, d); chk("R6 R1 status sw", d, 8'h05);
    chk("R6 ram_valid after sw", ram_valid, 1);
  endtask

  task automatic test_clear;
    int n; logic [7:0] d;
    wr(12'h234, 8'h01);
    count_rst(n); chk("R8 clear keeping bit2 resets", n, 4);
    rd(12'h230, d); chk("R7 R8 status after clear", d, 8'h04);
    wr(12'h234, 8'h04);
    @(negedge clk); chk("R8 clearing bit2 no reset", sys_rst, 0);
    rd(12'h230, d); chk("R7 bit2 cleared", d, 8'h00);
    wr(12'h234, 8'h01);
    @(negedge clk); chk("R8 no reset when bit2 clear", sys_rst, 0);
  endtask

  task automatic test_wdt;
    int n; logic [7:0] d;
    @(negedge clk); wdt_timeout = 1;
    @(posedge clk); #1 wdt_timeout = 0;
    chk("R5 wdt_rst low on timeout", wdt_rst, 0);
    count_rst(n); chk("R5 R3 wdt reset length", n, 4);
    rd(12'h230, d); chk("R5 status wdt", d, 8'h02);
  endtask

  task automatic test_ext;
    int n; logic [7:0] d;
    @(negedge clk); ext_rst_n = 0; #1;
    chk("R4 sys_rst on pin", sys_rst, 1);
    chk("R4 wdt_rst low on pin", wdt_rst, 0);
    wr(12'h230, 8'h04);
    wr(12'h234, 8'h02);
    @(negedge clk); ext_rst_n = 1;
    count_rst(n); chk("R3 R4 pin release hold", n, 5);
    rd(12'h230, d); chk("R4 R10 status ext ORed", d, 8'h0A);
    chk("R4 ram_valid", ram_valid, 1);
  endtask

  task automatic test_other_wr;
    logic [7:0] d;
    wr(12'h238, 8'hFF);
    @(negedge clk); chk("R9 other write no reset", sys_rst, 0);
    rd(12'h230, d); chk("R9 other write no change", d, 8'h0A);
    wr(12'h234, 8'h0F);
    @(negedge clk); chk("R8 full clear no reset", sys_rst, 0);
    rd(12'h230, d); chk("R7 full clear", d, 8'h00);
  endtask

  task automatic test_por_again;
    logic [7:0] d;
    test_wdt();
    test_por();
    rd(12'h230, d); chk("R2 por wipes causes", d, 8'h01);
    chk("R2 ram_valid after second por", ram_valid, 0);
  endtask

  initial begin
    test_por();
    test_reads();
    test_sw_write();
    test_clear();
    test_wdt();
    test_ext();
    test_other_wr();
    test_por_again();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule